// File: doc/BRIEF.md
# Transmit Descriptor Completion Sequencer

This block decides when each transmit descriptor of a ring is finished and when the ring head pointer may move past it. Descriptors reach it in ring order through a small prefetch queue. Each carries three command flags: end of packet, report status and report on send. A descriptor without the report-on-send request is treated as complete once it is in the queue, which stands for its data having been copied into the transmit FIFO. Such a descriptor retires on its own, or through a status write-back when report status is set.

A descriptor that has report on send set together with end of packet is held at the front of the queue. It waits until the MAC reports that the packet left the wire or was aborted on an error. While it waits, no status is written back for any descriptor and the head does not move. Prefetch of the descriptors behind it continues until the queue is full. The status write-back is a request/acknowledge handshake that carries the ring index and a two-bit status. The head pointer wraps at a ring length given on a port.

Top module: `txd_complete_seq`

## Requirements
- R1: After reset, `head_o` is 0, `wb_req_o` is low and `desc_ready_o` is high.
- R2: A queued descriptor that has neither report status nor an honoured report-on-send request retires without any write-back. `head_o` then advances by one, on the clock edge after the edge that accepted it, when it is at the front of the queue.
- R3: A descriptor with report status set, and without an honoured report-on-send request, raises `wb_req_o` with `wb_idx_o` equal to `head_o`. The request stays up, and the head stays put, until `wb_ack_i` is sampled high. The head advances on that edge.
- R4: A descriptor at the front with both report-on-send and end of packet set blocks all write-backs and head movement until a completion strobe arrives. Meanwhile new descriptors are still accepted until the queue holds DEPTH entries, and then `desc_ready_o` is low.
- R5: The write-back status has bit 0 as the done flag, which is always 1 during a request. Bit 1 is the error flag. It is 1 only for a held descriptor released by `tx_abort_i`, and 0 for one released by `tx_sent_i`. `wb_status_o` is 0 when no request is raised.
- R6: Report-on-send without end of packet in the same descriptor is ignored. The descriptor behaves as in R2 or R3.
- R7: `tx_sent_i` and `tx_abort_i` have no effect when the front descriptor is not held. They change neither the head nor the request, and they do not release a held descriptor that arrives later.
- R8: `head_o` counts 0 up to `ring_len_i`-1 and then wraps to 0.
- R9: Descriptors retire strictly in the order they were accepted, at most one per clock, and write-back indices follow ring order.
- R10: A completion strobe sampled at an edge while the front descriptor is held causes `wb_req_o` to be high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len_i | input | RING_W | Number of descriptors in the ring, at least 1, held constant |
| desc_valid_i | input | 1 | A prefetched descriptor is offered |
| desc_ready_o | output | 1 | Prefetch queue has room |
| desc_eop_i | input | 1 | Descriptor ends a packet |
| desc_rs_i | input | 1 | Descriptor requests a status write-back |
| desc_rps_i | input | 1 | Descriptor asks to be reported only after transmission |
| tx_sent_i | input | 1 | MAC strobe: held packet transmitted |
| tx_abort_i | input | 1 | MAC strobe: held packet ended in error |
| wb_req_o | output | 1 | Status write-back request |
| wb_ack_i | input | 1 | Write-back accepted |
| wb_idx_o | output | RING_W | Ring index of the descriptor being written back |
| wb_status_o | output | 2 | Bit 0 done, bit 1 error |
| head_o | output | RING_W | Ring head pointer |

## Verification
The hardest state to reach is a held report-on-send packet with a full prefetch queue behind it, where a completion strobe then releases a burst of retirements. Some of those need acknowledged write-backs and some do not, and they must cross the ring wrap in order. The stimulus parks a held descriptor at the front and feeds plain and report-status descriptors until `desc_ready_o` drops. It then pulses the send or abort strobe while the acknowledge follows an irregular pattern. A cycle-level behavioural model checks every output on every clock. Stray completion strobes while nothing is held, and report-on-send without end of packet, are checked to leave the head and the request unchanged.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef struct packed {
        logic eop;
        logic rs;
        logic rps;
    } txd_cmd_t;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

endpackage

// File: rtl/txd_fifo.sv
module txd_fifo
    import txd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  txd_cmd_t entry_i,
    input  logic     pop_i,
    output txd_cmd_t front_o,
    output logic     empty_o,
    output logic     full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    txd_cmd_t mem_q [DEPTH];
    logic     do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == CW'(DEPTH));
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        front_o = mem_q[st_q.rd];
        st_d    = st_q;
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= entry_i;
    end

endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter int RING_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RING_W-1:0] ring_len_i,
    input  logic              adv_i,
    output logic [RING_W-1:0] ptr_o
);
    logic [RING_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv_i) begin
            if (ptr_q == ring_len_i - 1'b1) ptr_d = '0;
            else                            ptr_d = ptr_q + 1'b1;
        end
        ptr_o = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/txd_complete_seq.sv
module txd_complete_seq
    import txd_pkg::*;
#(
    parameter int RING_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RING_W-1:0] ring_len_i,
    input  logic              desc_valid_i,
    output logic              desc_ready_o,
    input  logic              desc_eop_i,
    input  logic              desc_rs_i,
    input  logic              desc_rps_i,
    input  logic              tx_sent_i,
    input  logic              tx_abort_i,
    output logic              wb_req_o,
    input  logic              wb_ack_i,
    output logic [RING_W-1:0] wb_idx_o,
    output logic [1:0]        wb_status_o,
    output logic [RING_W-1:0] head_o
);
    typedef struct packed {
        logic comp;
        logic err;
    } seq_st_t;

    seq_st_t  st_d, st_q;
    txd_cmd_t in_cmd, front;
    logic     q_empty, q_full;
    logic     rps_eff, hold_w, need_wb, pop_w;

    assign in_cmd = '{eop: desc_eop_i, rs: desc_rs_i, rps: desc_rps_i};

    txd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (desc_valid_i),
        .entry_i (in_cmd),
        .pop_i   (pop_w),
        .front_o (front),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    txd_ring_ptr #(.RING_W(RING_W)) u_head (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_len_i (ring_len_i),
        .adv_i      (pop_w),
        .ptr_o      (head_o)
    );

    always_comb begin
        rps_eff  = !q_empty && front.rps && front.eop;
        hold_w   = rps_eff && !st_q.comp;
        need_wb  = !q_empty && (front.rs || rps_eff);
        wb_req_o = need_wb && !hold_w;
        pop_w    = !q_empty && !hold_w && (!need_wb || wb_ack_i);

        desc_ready_o = !q_full;
        wb_idx_o     = head_o;
        wb_status_o  = '0;
        if (wb_req_o) begin
            wb_status_o[STAT_DONE_BIT] = 1'b1;
            wb_status_o[STAT_ERR_BIT]  = st_q.err;
        end

        st_d = st_q;
        if (pop_w) begin
            st_d = '0;
        end else if (hold_w && (tx_sent_i || tx_abort_i)) begin
            st_d.comp = 1'b1;
            st_d.err  = tx_abort_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/txd_complete_chk.sv
module txd_complete_chk #(
    parameter int RING_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RING_W-1:0] ring_len_i,
    input logic              hold_w,
    input logic              wb_req_o,
    input logic              wb_ack_i,
    input logic [RING_W-1:0] wb_idx_o,
    input logic [1:0]        wb_status_o,
    input logic [RING_W-1:0] head_o
);
    AST_REQ_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_idx_o)); // R3

    AST_HEAD_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o && !wb_ack_i |=> $stable(head_o)); // R3

    AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hold_w |-> !wb_req_o); // R4

    AST_HOLD_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_w |=> $stable(head_o)); // R4

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> wb_status_o[0]); // R5

    AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        head_o < ring_len_i); // R8

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_o) |-> ((head_o == $past(head_o) + 1'b1) ||
                              (head_o == '0 && $past(head_o) == ring_len_i - 1'b1))); // R8

endmodule

bind txd_complete_seq txd_complete_chk #(.RING_W(RING_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_len_i  (ring_len_i),
    .hold_w      (hold_w),
    .wb_req_o    (wb_req_o),
    .wb_ack_i    (wb_ack_i),
    .wb_idx_o    (wb_idx_o),
    .wb_status_o (wb_status_o),
    .head_o      (head_o)
);

// File: tb/txd_complete_seq_test.sv
`timescale 1ns/1ps
module txd_complete_seq_test;
    localparam int RING_W = 8;
    localparam int DEPTH  = 4;
    localparam int RLEN   = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic [RING_W-1:0] ring_len_i = RING_W'(RLEN);
    logic desc_valid_i = 0, desc_eop_i = 0, desc_rs_i = 0, desc_rps_i = 0;
    logic tx_sent_i = 0, tx_abort_i = 0, wb_ack_i = 0;
    logic desc_ready_o, wb_req_o;
    logic [RING_W-1:0] wb_idx_o, head_o;
    logic [1:0] wb_status_o;

    always #2 clk = ~clk;

    txd_complete_seq #(.RING_W(RING_W), .DEPTH(DEPTH)) uut (.*);

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit ack_en = 0, finished = 0;

    typedef struct { bit eop; bit rs; bit rps; } mdesc_t;
    mdesc_t mq[$];
    int  mhead = 0;
    bit  mcomp = 0, merr = 0;

    function automatic bit m_rps();
        return mq.size() > 0 && mq[0].rps && mq[0].eop;
    endfunction
    function automatic bit m_hold();
        return m_rps() && !mcomp;
    endfunction
    function automatic bit m_need();
        return mq.size() > 0 && (mq[0].rs || m_rps());
    endfunction
    function automatic bit m_req();
        return m_need() && !m_hold();
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq.delete(); mhead = 0; mcomp = 0; merr = 0;
        end else begin
            bit hold, need, pop, push;
            hold = m_hold();
            need = m_need();
            pop  = mq.size() > 0 && !hold && (!need || wb_ack_i);
            push = desc_valid_i && (mq.size() < DEPTH);
            if (pop) begin
                mcomp = 0; merr = 0;
                void'(mq.pop_front());
                mhead = (mhead + 1) % RLEN;
            end else if (hold && (tx_sent_i || tx_abort_i)) begin
                mcomp = 1; merr = tx_abort_i;
            end
            if (push) mq.push_back('{desc_eop_i, desc_rs_i, desc_rps_i});
        end
    end

    // per-cycle comparison
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            bit er;
            er = m_req();
            chk(head_o == RING_W'(mhead), "R9 head order", head_o, mhead);
            chk(wb_req_o == er, "R4 wb_req", wb_req_o, er);
            chk(desc_ready_o == (mq.size() < DEPTH), "R4 ready", desc_ready_o, mq.size() < DEPTH);
            if (er) begin
                chk(wb_idx_o == RING_W'(mhead), "R9 wb_idx", wb_idx_o, mhead);
                chk(wb_status_o == {merr, 1'b1}, "R5 status", wb_status_o, {merr, 1'b1});
            end else begin
                chk(wb_status_o == 2'b00, "R5 idle status", wb_status_o, 0);
            end
        end
    end

    // acknowledge pattern
    always @(negedge clk) wb_ack_i <= ack_en && ((cyc % 3) != 1);

    task automatic send(input bit eop, input bit rs, input bit rps);
        bit rdy;
        @(negedge clk);
        desc_valid_i = 1; desc_eop_i = eop; desc_rs_i = rs; desc_rps_i = rps;
        forever begin
            rdy = desc_ready_o;
            @(negedge clk);
            if (rdy) break;
        end
        desc_valid_i = 0; desc_eop_i = 0; desc_rs_i = 0; desc_rps_i = 0;
    endtask

    task automatic pulse(input bit err);
        @(negedge clk);
        tx_sent_i = !err; tx_abort_i = err;
        @(negedge clk);
        tx_sent_i = 0; tx_abort_i = 0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((mq.size() != 0) && guard < 200) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(head_o == 0, "R1 head", head_o, 0);
        chk(wb_req_o == 0, "R1 wb_req", wb_req_o, 0);
        chk(desc_ready_o == 1, "R1 ready", desc_ready_o, 1);

        // R2: plain descriptor, no write-back
        send(1, 0, 0);
        @(negedge clk);
        chk(head_o == 1, "R2 plain advance", head_o, 1);

        // R3: report status, no ack yet
        send(1, 1, 0);
        repeat (3) @(negedge clk);
        chk(wb_req_o == 1, "R3 req held", wb_req_o, 1);
        chk(wb_idx_o == 1 && head_o == 1, "R3 idx/head", wb_idx_o, 1);
        ack_en = 1;
        drain();
        chk(head_o == 2, "R3 head after ack", head_o, 2);

        // R4/R10/R5: hold with full queue, release by send
        h = mhead;
        send(1, 1, 1);
        send(1, 0, 0); send(0, 1, 0); send(1, 1, 0);
        repeat (3) @(negedge clk);
        chk(desc_ready_o == 0, "R4 queue full", desc_ready_o, 0);
        chk(head_o == RING_W'(h), "R4 head frozen", head_o, h);
        chk(wb_req_o == 0, "R4 no write-back", wb_req_o, 0);
        pulse(0);
        chk(wb_req_o == 1, "R10 req after strobe", wb_req_o, 1);
        chk(wb_status_o == 2'b01, "R5 sent status", wb_status_o, 1);
        drain();
        chk(head_o == RING_W'((h + 4) % RLEN), "R8 wrap", head_o, (h + 4) % RLEN);

        // R5: abort path
        send(1, 0, 1);
        repeat (2) @(negedge clk);
        pulse(1);
        chk(wb_status_o == 2'b11, "R5 abort status", wb_status_o, 3);
        drain();

        // R6: report-on-send without end of packet
        h = mhead;
        send(0, 0, 1);
        repeat (2) @(negedge clk);
        chk(head_o == RING_W'((h + 1) % RLEN), "R6 not held", head_o, (h + 1) % RLEN);

        // R7: stray strobes
        h = mhead;
        pulse(0); pulse(1);
        chk(head_o == RING_W'(h) && wb_req_o == 0, "R7 stray strobe", head_o, h);
        send(1, 0, 1);
        repeat (5) @(negedge clk);
        chk(head_o == RING_W'(h) && wb_req_o == 0, "R7 later hold kept", head_o, h);
        pulse(0);
        drain();

        // R9/R8: mixed stream across several wraps
        for (int i = 0; i < 24; i++) begin
            send(((i % 3) != 0), ((i % 2) == 0), ((i % 7) == 3));
            if ((i % 7) == 3) fork begin repeat (4) @(negedge clk); pulse(i % 2 == 1); end join_none
        end
        repeat (10) @(negedge clk);
        drain();
        chk(mq.size() == 0, "R9 stream drained", mq.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule